// File: doc/BRIEF.md
# Microcode SRAM Load Port

This block gives a host a small register window onto a byte-wide program SRAM that belongs to an embedded processor, together with the register that holds that processor stopped or lets it run. The host uses a simple register bus with an 8-bit register index and 32-bit data. To load a program, it halts the processor with host access enabled and sets a hidden pointer to zero. It then writes the program one byte at a time into a single data register. Each data access moves the pointer forward by one.

To verify the load, the host rewinds the pointer and reads the same data register repeatedly. Each read returns one stored byte, zero-extended, and advances the pointer. When the image is in place, the host writes the start pattern to the control register. That releases the processor's reset hold and enables its clock. The processor itself is not part of this block; only its control outputs are driven.

Bus reads are registered. Read data and its valid flag appear in the cycle after the request. Writes take effect at the clock edge that samples them.

Top module: `ucode_loader`

## Requirements
- R1: After reset the control register and the pointer are zero, `cpu_run` is low and `rd_valid` is low.
- R2: A write to index 0x11 loads the pointer with the low log2(DEPTH) bits of the write data. A read of 0x11 returns the pointer, zero-extended.
- R3: A write to index 0x12 while host access is enabled stores write-data bits 7:0 at the pointer and then advances the pointer by one.
- R4: A read of index 0x12 while host access is enabled returns the byte at the pointer in bits 7:0 and zero in bits 31:8, then advances the pointer. Every read's data is on `rd_data`, with `rd_valid` high, in the cycle after the request.
- R5: The pointer wraps from DEPTH-1 to 0, for both data writes and data reads.
- R6: While control bit 2 (host access enable) is clear, a write to 0x12 changes neither the SRAM nor the pointer. A read of 0x12 returns zero and leaves the pointer where it was.
- R7: Index 0x10 holds a 9-bit control word, read back zero-extended. The bits are: bit 8 clock divide, bit 7 reset hold, bit 3 boot enable, bit 2 host access enable, bit 1 clock enable, bit 0 soft reset. Bits 8, 7, 3 and 0 appear on `cpu_clk_div`, `cpu_rst_hold`, `cpu_boot_en` and `cpu_soft_rst`.
- R8: `cpu_run` is high exactly when clock enable is set and reset hold is clear. The stop word 0x08C gives `cpu_run` low with host access enabled. The start word 0x10B gives `cpu_run` high with host access disabled.
- R9: Reads of any other index return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 8 | Register index |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (cycle after a read request) |
| rd_data | output | 32 | Read data |
| cpu_run | output | 1 | Embedded processor allowed to run |
| cpu_rst_hold | output | 1 | Reset hold bit |
| cpu_soft_rst | output | 1 | Soft reset bit |
| cpu_clk_div | output | 1 | Clock divide bit |
| cpu_boot_en | output | 1 | Boot enable bit |

## Verification
The hardest case to reach from the ports is the pointer crossing from the last SRAM location back to zero. A long stream would take DEPTH accesses to get there. The bench instead loads the pointer with DEPTH-1 directly, writes two bytes, then rewinds and reads them back, so that both the store and the read cross the wrap. Blocked accesses are exposed by clearing host access in the middle of a stream and then re-enabling it. Reading back the pointer and the bytes around it then shows that nothing moved.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
  localparam logic [7:0] IDX_CTRL = 8'h10;
  localparam logic [7:0] IDX_PTR  = 8'h11;
  localparam logic [7:0] IDX_DATA = 8'h12;

  localparam int CW        = 9;
  localparam int B_SRST    = 0;
  localparam int B_CLKEN   = 1;
  localparam int B_EXTACC  = 2;
  localparam int B_BOOT    = 3;
  localparam int B_HOLD    = 7;
  localparam int B_CLKDIV  = 8;

  typedef enum logic [1:0] {SRC_NONE, SRC_SNAP, SRC_SRAM} rsrc_e;

  function automatic logic run_of(input logic [CW-1:0] c);
    return c[B_CLKEN] & ~c[B_HOLD];
  endfunction

  function automatic logic [31:0] widen_byte(input logic [7:0] b);
    return {24'd0, b};
  endfunction
endpackage

// File: rtl/ucl_ptr.sv
module ucl_ptr #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (step_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  p_ptr_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (ptr_o != $past(ptr_o)));
  p_ptr_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(ptr_o));
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_o == LAST) |=> (ptr_o == '0));
endmodule

// File: rtl/ucl_sram.sv
module ucl_sram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    q_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) q_o <= mem[addr_i];
  end
endmodule

// File: rtl/ucl_ctrl.sv
module ucl_ctrl
  import ucl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] ctrl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_o <= '0;
    else if (wr_i) ctrl_o <= wdata_i;
  end

  p_ctrl_only_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
  import ucl_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_idx,
  input  logic [31:0] bus_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        cpu_run,
  output logic        cpu_rst_hold,
  output logic        cpu_soft_rst,
  output logic        cpu_clk_div,
  output logic        cpu_boot_en
);
  logic [CW-1:0] ctrl;
  logic [AW-1:0] ptr;
  logic [7:0]    sram_q;

  // named access events
  logic wr_evt, rd_evt, host_ok;
  logic ctrl_wr_evt, ptr_wr_evt, data_wr_evt, data_rd_evt, step_evt;
  assign wr_evt      = bus_sel & bus_we;
  assign rd_evt      = bus_sel & ~bus_we;
  assign host_ok     = ctrl[B_EXTACC];
  assign ctrl_wr_evt = wr_evt & (bus_idx == IDX_CTRL);
  assign ptr_wr_evt  = wr_evt & (bus_idx == IDX_PTR);
  assign data_wr_evt = wr_evt & (bus_idx == IDX_DATA) & host_ok;
  assign data_rd_evt = rd_evt & (bus_idx == IDX_DATA) & host_ok;
  assign step_evt    = data_wr_evt | data_rd_evt;

  ucl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr_evt),
    .wdata_i(bus_wdata[CW-1:0]), .ctrl_o(ctrl)
  );

  ucl_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_wr_evt),
    .load_val_i(bus_wdata[AW-1:0]), .step_i(step_evt), .ptr_o(ptr)
  );

  ucl_sram #(.DEPTH(DEPTH)) u_sram (
    .clk(clk), .we_i(data_wr_evt), .re_i(data_rd_evt),
    .addr_i(ptr), .wdata_i(bus_wdata[7:0]), .q_o(sram_q)
  );

  // registered read path
  rsrc_e       rsrc_q;
  logic [31:0] snap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rsrc_q   <= SRC_NONE;
      snap_q   <= '0;
    end else begin
      rd_valid <= rd_evt;
      if (rd_evt) begin
        if (data_rd_evt) begin
          rsrc_q <= SRC_SRAM;
          snap_q <= '0;
        end else if (bus_idx == IDX_CTRL) begin
          rsrc_q <= SRC_SNAP;
          snap_q <= 32'(ctrl);
        end else if (bus_idx == IDX_PTR) begin
          rsrc_q <= SRC_SNAP;
          snap_q <= 32'(ptr);
        end else begin
          rsrc_q <= SRC_NONE;
          snap_q <= '0;
        end
      end
    end
  end

  always_comb begin
    unique case (rsrc_q)
      SRC_SRAM: rd_data = widen_byte(sram_q);
      SRC_SNAP: rd_data = snap_q;
      default:  rd_data = '0;
    endcase
  end

  assign cpu_run      = run_of(ctrl);
  assign cpu_rst_hold = ctrl[B_HOLD];
  assign cpu_soft_rst = ctrl[B_SRST];
  assign cpu_clk_div  = ctrl[B_CLKDIV];
  assign cpu_boot_en  = ctrl[B_BOOT];

  p_read_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> rd_valid);
  p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_evt |=> (rd_data[31:8] == 24'd0));
  p_blocked_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && bus_idx == IDX_DATA && !host_ok) |=> (rd_data == 32'd0));
  p_run_needs_ctrl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> $past(ctrl_wr_evt));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && bus_idx != IDX_CTRL && bus_idx != IDX_PTR && bus_idx != IDX_DATA)
      |=> (rd_data == 32'd0));
endmodule

// File: tb/test_ucode_loader.sv
module test_ucode_loader;
  localparam int DEPTH = 2048;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic rd_valid, cpu_run, cpu_rst_hold, cpu_soft_rst, cpu_clk_div, cpu_boot_en;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  ucode_loader #(.DEPTH(DEPTH)) i_ucode_loader (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .cpu_run(cpu_run), .cpu_rst_hold(cpu_rst_hold),
    .cpu_soft_rst(cpu_soft_rst), .cpu_clk_div(cpu_clk_div),
    .cpu_boot_en(cpu_boot_en)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] model_mem [DEPTH];
  logic [7:0] written [DEPTH];
  int m_ptr = 0;
  logic [8:0] m_ctrl = '0;

  function automatic int ptr_after(input int p);
    return (p + 1) % DEPTH;
  endfunction
  function automatic logic exp_run(input logic [8:0] c);
    return c[1] && !c[7];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    if (idx == 8'h10) m_ctrl = d[8:0];
    else if (idx == 8'h11) m_ptr = int'(d[AW-1:0]);
    else if (idx == 8'h12 && m_ctrl[2]) begin
      model_mem[m_ptr] = d[7:0]; written[m_ptr] = 1'b1; m_ptr = ptr_after(m_ptr);
    end
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_idx = idx;
    @(negedge clk);
    bus_sel = 1'b0;
    check("R4 rd_valid", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic rd_data_chk(input string req);
    logic [31:0] v;
    logic [31:0] e;
    e = (m_ctrl[2] && written[m_ptr]) ? {24'd0, model_mem[m_ptr]} : 32'd0;
    rd(8'h12, v);
    if (m_ctrl[2] && !written[m_ptr]) e = {24'd0, v[7:0]};
    check(req, v, e);
    if (m_ctrl[2]) m_ptr = ptr_after(m_ptr);
  endtask

  task automatic ptr_chk(input string req);
    logic [31:0] v;
    rd(8'h11, v);
    check(req, v, 32'(m_ptr));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) written[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 run", 32'(cpu_run), 32'd0);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    rd(8'h10, v); check("R1 ctrl", v, 32'd0);
    ptr_chk("R1 ptr");

    // R7/R8 stop pattern
    wr(8'h10, 32'h0000_008C);
    rd(8'h10, v); check("R7 ctrl readback", v, 32'h8C);
    check("R8 stop run", 32'(cpu_run), 32'(exp_run(m_ctrl)));
    check("R7 hold out", 32'(cpu_rst_hold), 32'd1);
    check("R7 boot out", 32'(cpu_boot_en), 32'd1);

    // R2 pointer set and readback (upper bits dropped)
    wr(8'h11, 32'hFFFF_0000 | 32'd37);
    ptr_chk("R2 ptr load");
    wr(8'h11, 32'd0);
    ptr_chk("R2 ptr zero");

    // R3 stream a program
    for (int i = 0; i < 40; i++) wr(8'h12, $urandom());
    ptr_chk("R3 ptr advanced");
    wr(8'h11, 32'd0);
    for (int i = 0; i < 40; i++) rd_data_chk("R4 verify byte");
    ptr_chk("R4 ptr advanced");

    // R5 wrap on write and read
    wr(8'h11, DEPTH - 1);
    wr(8'h12, 32'h1234_56AA);
    wr(8'h12, 32'h0000_00BB);
    ptr_chk("R5 wrap write ptr");
    wr(8'h11, DEPTH - 1);
    rd_data_chk("R5 last byte");
    ptr_chk("R5 wrap read ptr");
    rd_data_chk("R5 first byte");

    // R6 host access disabled
    wr(8'h11, 32'd5);
    wr(8'h10, 32'h0000_0080);
    wr(8'h12, 32'h0000_0077);
    ptr_chk("R6 write ptr hold");
    rd_data_chk("R6 read zero");
    ptr_chk("R6 read ptr hold");
    wr(8'h10, 32'h0000_0004);
    rd_data_chk("R6 byte unchanged");

    // R9 unmapped
    wr(8'h13, 32'hFFFF_FFFF);
    rd(8'h13, v); check("R9 unmapped read", v, 32'd0);
    rd(8'h10, v); check("R9 ctrl untouched", v, 32'h004);
    ptr_chk("R9 ptr untouched");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) wr(8'h12, $urandom());
      else if (op < 8) rd_data_chk("R4 random read");
      else if (op == 8) wr(8'h11, $urandom());
      else ptr_chk("R2 random ptr");
    end

    // R8 start pattern
    wr(8'h10, 32'h0000_010B);
    check("R8 start run", 32'(cpu_run), 32'(exp_run(m_ctrl)));
    check("R7 clkdiv out", 32'(cpu_clk_div), 32'd1);
    check("R7 srst out", 32'(cpu_soft_rst), 32'd1);
    rd_data_chk("R8 access off after start");
    wr(8'h10, 32'h0000_0082);
    check("R8 hold blocks run", 32'(cpu_run), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule